// File: doc/BRIEF.md
# EEPROM Configuration Autoload Sequencer

This block fetches a board's configuration words from a serial EEPROM through a separate word-read master and keeps the results in registers. It runs once on its own after reset. It can run again on a reload request, or on a field query that arrives when the held copy is no longer current. It issues single-word reads strictly one at a time and waits for the master to finish each one. The first word read is an identification word. The version byte and the six MAC address bytes are always fetched. The RF type bit and the crystal trim nibble are fetched only when the identification word matches the expected constant.

The block keeps two status flags. The first says that a load finished and the held copy is current. The second says that the load failed, either because the identification word did not match or because the master reported an error. A host write to the EEPROM makes the held copy stale, so the next field query reloads it. While the fail flag is set, queries get a not-valid response. The serial protocol itself lives in the master and is not part of this block.

Top module: `eeload_seq`

## Requirements
- R1: After reset is released, a load starts without any request. Its first read is word address 0, and that word is compared with the parameter ID_WORD.
- R2: Reads come in this order: word 0, word 0x3E, MAC_WORD_BASE, MAC_WORD_BASE+1, MAC_WORD_BASE+2, and then, only on an ID match, 0x14 and 0x15. Each read is a one-cycle `rdReq` pulse. The next read is issued only after `rdDone`.
- R3: `verByte` takes bits 15:8 of word 0x3E.
- R4: MAC word k (k = 0..2) fills `macAddr[16k+15:16k]`. Its low byte is MAC byte 2k and its high byte is MAC byte 2k+1.
- R5: On an ID mismatch, exactly five reads are made and `loadFail` is set. `rfType` and `xtalTrim` read 0, because every field is cleared when a load starts. The version and MAC fields are still captured.
- R6: On an ID match, `rfType` takes bit 7 of word 0x14 and `xtalTrim` takes bits 15:12 of word 0x15.
- R7: `cfgWideAddr` is sampled when a load starts and is shown on `rdWide`. When it is 0, bits 7:6 of `rdAddr` are 0, which gives 6-bit addresses. When it is 1, the full 8-bit address is sent. A change to `cfgWideAddr` during a load has no effect on that load.
- R8: `cached` rises when a load ends and stays 0 while a load is running. `fieldValid` is 1 exactly when `cached` is 1 and `loadFail` is 0.
- R9: `hostWrReq` clears `cached` on the next cycle. A `qryReq` while the block is idle and `cached` is 0 starts a load. A `qryReq` while `cached` is 1 issues no read.
- R10: `rdErr` ends the load at once. No further reads are made, and the load ends with `loadFail`=1 and `cached`=1. If `rdErr` and `rdDone` arrive together, `rdErr` wins and the word is not captured.
- R11: A `hostWrReq` during a load lets the load finish but leaves `cached` at 0.
- R12: A `reloadReq` while the block is idle starts a new load even when `cached` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWideAddr | input | 1 | 1 selects 8-bit read addresses, 0 selects 6-bit |
| reloadReq | input | 1 | Starts a load when the block is idle |
| qryReq | input | 1 | Field access; starts a load if the copy is not current |
| hostWrReq | input | 1 | A host write to the EEPROM has happened |
| rdReq | output | 1 | One-cycle read request to the master |
| rdAddr | output | ADDR_W | Word address of the read |
| rdWide | output | 1 | Address width in use for this load |
| rdDone | input | 1 | Master pulse: read word is on `rdData` |
| rdErr | input | 1 | Master pulse: read failed or timed out |
| rdData | input | 16 | Word returned by the master |
| busy | output | 1 | A load is in progress |
| cached | output | 1 | The held copy is current |
| loadFail | output | 1 | The last load failed |
| fieldValid | output | 1 | Field outputs may be used |
| macAddr | output | 48 | MAC bytes, byte n at bits 8n+7:8n |
| verByte | output | 8 | Version byte |
| rfType | output | 1 | RF type bit |
| xtalTrim | output | TRIM_W | Crystal trim |

## Verification
The bench builds the block with ID_WORD = 16'hC35A and MAC_WORD_BASE = 8'h45. The MAC base then has bit 6 set, so 6-bit loads must send MAC addresses 0x05 to 0x07 while 8-bit loads send 0x45 to 0x47, and a missing address mask shows up in the logged read sequence. The EEPROM model answers with random latency. It can inject an error, alone or together with a done pulse, at any read position, which reaches every partial-capture state.

// File: rtl/eeload_pkg.sv
package eeload_pkg;

  localparam int MAC_WORDS = 3;

  typedef enum logic [2:0] {
    STEP_ID   = 3'd0,
    STEP_VER  = 3'd1,
    STEP_MAC0 = 3'd2,
    STEP_MAC1 = 3'd3,
    STEP_MAC2 = 3'd4,
    STEP_RF   = 3'd5,
    STEP_TRIM = 3'd6
  } loadStep_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_WAIT = 2'd2
  } seqPhase_e;

  typedef struct packed {
    logic      start;
    logic      capture;
    logic      finishOk;
    logic      finishErr;
    loadStep_e step;
  } seqStrobe_t;

endpackage

// File: rtl/eeload_ctrl.sv
module eeload_ctrl
  import eeload_pkg::*;
#(
  parameter int                ADDR_W        = 8,
  parameter int                NARROW_W      = 6,
  parameter logic [ADDR_W-1:0] VER_WORD      = 'h3E,
  parameter logic [ADDR_W-1:0] MAC_WORD_BASE = 'h08,
  parameter logic [ADDR_W-1:0] RF_WORD       = 'h14,
  parameter logic [ADDR_W-1:0] TRIM_WORD     = 'h15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWideAddr,
  input  logic              reloadReq,
  input  logic              qryReq,
  input  logic              cachedQ,
  input  logic              idMatchQ,
  input  logic              rdDone,
  input  logic              rdErr,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdWide,
  output logic              busy,
  output seqStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] NARROW_MASK = ADDR_W'((1 << NARROW_W) - 1);

  seqPhase_e phaseQ, phaseD;
  loadStep_e stepQ, stepD;
  logic      bootPendQ;
  logic      wideQ;
  logic      lastStep;
  logic      startNow;
  logic [ADDR_W-1:0] wordAddr;

  assign lastStep = (stepQ == STEP_TRIM) || ((stepQ == STEP_MAC2) && !idMatchQ);
  assign startNow = (phaseQ == PH_IDLE) && (bootPendQ || reloadReq || (qryReq && !cachedQ));

  always_comb begin
    strobe      = '0;
    strobe.step = stepQ;
    phaseD      = phaseQ;
    stepD       = stepQ;
    unique case (phaseQ)
      PH_IDLE: begin
        if (startNow) begin
          strobe.start = 1'b1;
          phaseD       = PH_REQ;
          stepD        = STEP_ID;
        end
      end
      PH_REQ: phaseD = PH_WAIT;
      PH_WAIT: begin
        if (rdErr) begin
          strobe.finishErr = 1'b1;
          phaseD           = PH_IDLE;
        end else if (rdDone) begin
          strobe.capture = 1'b1;
          if (lastStep) begin
            strobe.finishOk = 1'b1;
            phaseD          = PH_IDLE;
          end else begin
            stepD  = loadStep_e'(3'(stepQ + 3'd1));
            phaseD = PH_REQ;
          end
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ    <= PH_IDLE;
      stepQ     <= STEP_ID;
      bootPendQ <= 1'b1;
      wideQ     <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      stepQ  <= stepD;
      if (startNow) begin
        bootPendQ <= 1'b0;
        wideQ     <= cfgWideAddr;
      end
    end
  end

  always_comb begin
    unique case (stepQ)
      STEP_ID:   wordAddr = '0;
      STEP_VER:  wordAddr = VER_WORD;
      STEP_MAC0: wordAddr = MAC_WORD_BASE;
      STEP_MAC1: wordAddr = ADDR_W'(MAC_WORD_BASE + 1);
      STEP_MAC2: wordAddr = ADDR_W'(MAC_WORD_BASE + 2);
      STEP_RF:   wordAddr = RF_WORD;
      STEP_TRIM: wordAddr = TRIM_WORD;
      default:   wordAddr = '0;
    endcase
  end

  assign rdAddr = wideQ ? wordAddr : (wordAddr & NARROW_MASK);
  assign rdReq  = (phaseQ == PH_REQ);
  assign rdWide = wideQ;
  assign busy   = (phaseQ != PH_IDLE);

  // R2
  rd_req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R1
  first_read_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (rdReq && (rdAddr == '0)));

  // R7
  narrow_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdWide) |-> ((rdAddr & ~NARROW_MASK) == '0));

  // R10
  load_end_on_reply_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(rdDone || rdErr));

endmodule

// File: rtl/eeload_dp.sv
module eeload_dp
  import eeload_pkg::*;
#(
  parameter logic [15:0] ID_WORD  = 16'h8129,
  parameter int          RF_BIT   = 7,
  parameter int          TRIM_LSB = 12,
  parameter int          TRIM_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [15:0]       rdData,
  input  logic              hostWrReq,
  output logic              cachedQ,
  output logic              failQ,
  output logic              idMatchQ,
  output logic [16*MAC_WORDS-1:0] macAddr,
  output logic [7:0]        verByte,
  output logic              rfType,
  output logic [TRIM_W-1:0] xtalTrim
);

  logic [15:0]       macWordQ [MAC_WORDS];
  logic [7:0]        verQ;
  logic              rfQ;
  logic [TRIM_W-1:0] trimQ;
  logic              staleQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cachedQ  <= 1'b0;
      failQ    <= 1'b0;
      idMatchQ <= 1'b0;
      staleQ   <= 1'b0;
      verQ     <= '0;
      rfQ      <= 1'b0;
      trimQ    <= '0;
    end else begin
      if (strobe.start) begin
        cachedQ  <= 1'b0;
        failQ    <= 1'b0;
        idMatchQ <= 1'b0;
        staleQ   <= 1'b0;
        verQ     <= '0;
        rfQ      <= 1'b0;
        trimQ    <= '0;
      end
      if (strobe.capture) begin
        unique case (strobe.step)
          STEP_ID:   idMatchQ <= (rdData == ID_WORD);
          STEP_VER:  verQ     <= rdData[15:8];
          STEP_RF:   rfQ      <= rdData[RF_BIT];
          STEP_TRIM: trimQ    <= rdData[TRIM_LSB +: TRIM_W];
          default:   ;
        endcase
      end
      if (strobe.finishOk) begin
        cachedQ <= !staleQ;
        failQ   <= !idMatchQ;
      end
      if (strobe.finishErr) begin
        cachedQ <= !staleQ;
        failQ   <= 1'b1;
      end
      if (hostWrReq) begin
        cachedQ <= 1'b0;
        if (!strobe.start) staleQ <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < MAC_WORDS; k++) begin
      if (!rstN || strobe.start) begin
        macWordQ[k] <= '0;
      end else if (strobe.capture && (strobe.step == loadStep_e'(3'(STEP_MAC0 + k)))) begin
        macWordQ[k] <= rdData;
      end
    end
  end

  for (genvar g = 0; g < MAC_WORDS; g++) begin : g_mac
    assign macAddr[16*g +: 16] = macWordQ[g];
  end

  assign verByte  = verQ;
  assign rfType   = rfQ;
  assign xtalTrim = trimQ;

  // R9
  host_wr_clears_cache_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWrReq |=> !cachedQ);

  // R8
  cache_set_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cachedQ) |-> $past(strobe.finishOk || strobe.finishErr));

  // R6
  rf_read_needs_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && (strobe.step == STEP_RF)) |-> idMatchQ);

endmodule

// File: rtl/eeload_seq.sv
module eeload_seq
  import eeload_pkg::*;
#(
  parameter int                ADDR_W        = 8,
  parameter int                NARROW_W      = 6,
  parameter logic [15:0]       ID_WORD       = 16'h8129,
  parameter logic [ADDR_W-1:0] VER_WORD      = 'h3E,
  parameter logic [ADDR_W-1:0] MAC_WORD_BASE = 'h08,
  parameter logic [ADDR_W-1:0] RF_WORD       = 'h14,
  parameter int                RF_BIT        = 7,
  parameter logic [ADDR_W-1:0] TRIM_WORD     = 'h15,
  parameter int                TRIM_LSB      = 12,
  parameter int                TRIM_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWideAddr,
  input  logic              reloadReq,
  input  logic              qryReq,
  input  logic              hostWrReq,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdWide,
  input  logic              rdDone,
  input  logic              rdErr,
  input  logic [15:0]       rdData,
  output logic              busy,
  output logic              cached,
  output logic              loadFail,
  output logic              fieldValid,
  output logic [47:0]       macAddr,
  output logic [7:0]        verByte,
  output logic              rfType,
  output logic [TRIM_W-1:0] xtalTrim
);

  seqStrobe_t strobe;
  logic       cachedQ;
  logic       failQ;
  logic       idMatchQ;

  eeload_ctrl #(
    .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .VER_WORD(VER_WORD),
    .MAC_WORD_BASE(MAC_WORD_BASE), .RF_WORD(RF_WORD), .TRIM_WORD(TRIM_WORD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWideAddr(cfgWideAddr), .reloadReq(reloadReq),
    .qryReq(qryReq), .cachedQ(cachedQ), .idMatchQ(idMatchQ), .rdDone(rdDone),
    .rdErr(rdErr), .rdReq(rdReq), .rdAddr(rdAddr), .rdWide(rdWide),
    .busy(busy), .strobe(strobe)
  );

  eeload_dp #(
    .ID_WORD(ID_WORD), .RF_BIT(RF_BIT), .TRIM_LSB(TRIM_LSB), .TRIM_W(TRIM_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData),
    .hostWrReq(hostWrReq), .cachedQ(cachedQ), .failQ(failQ),
    .idMatchQ(idMatchQ), .macAddr(macAddr), .verByte(verByte),
    .rfType(rfType), .xtalTrim(xtalTrim)
  );

  assign cached     = cachedQ;
  assign loadFail   = failQ;
  assign fieldValid = cachedQ && !failQ;

  // R9
  no_read_while_cached_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> !cached);

endmodule

// File: tb/eeload_seq_bench.sv
module eeload_seq_bench;

  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] ID_VAL     = 16'hC35A;
  localparam logic [7:0]  MAC_BASE   = 8'h45;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWideAddr = 1'b1, reloadReq = 1'b0, qryReq = 1'b0, hostWrReq = 1'b0;
  logic rdReq, rdWide, rdDone = 1'b0, rdErr = 1'b0;
  logic [7:0]  rdAddr;
  logic [15:0] rdData = '0;
  logic busy, cached, loadFail, fieldValid, rfType;
  logic [47:0] macAddr;
  logic [7:0]  verByte;
  logic [3:0]  xtalTrim;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeload_seq #(.ID_WORD(ID_VAL), .MAC_WORD_BASE(MAC_BASE)) u_eeload_seq (
    .clk(clk), .rstN(rstN), .cfgWideAddr(cfgWideAddr), .reloadReq(reloadReq),
    .qryReq(qryReq), .hostWrReq(hostWrReq), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdWide(rdWide), .rdDone(rdDone), .rdErr(rdErr), .rdData(rdData),
    .busy(busy), .cached(cached), .loadFail(loadFail), .fieldValid(fieldValid),
    .macAddr(macAddr), .verByte(verByte), .rfType(rfType), .xtalTrim(xtalTrim)
  );

  logic [15:0] mem [256];
  logic [7:0]  logAddr [16];
  int readsSeen = 0;
  int errIdx = -1;
  bit errBoth = 0;
  int pend = 0;
  logic [7:0] pendAddr;
  int total = 0, fails = 0;
  int cyc = 0;
  bit finished = 0;

  // EEPROM master model with random latency and error injection
  always @(negedge clk) begin
    rdDone <= 1'b0;
    rdErr  <= 1'b0;
    if (!rstN) begin
      pend = 0;
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        if (errIdx == readsSeen - 1) begin
          rdErr  <= 1'b1;
          rdDone <= errBoth;
          rdData <= mem[pendAddr];
        end else begin
          rdDone <= 1'b1;
          rdData <= mem[pendAddr];
        end
      end
    end else if (rdReq) begin
      if (readsSeen < 16) logAddr[readsSeen] = rdAddr;
      readsSeen++;
      pendAddr = rdAddr;
      pend = 1 + int'($urandom % 4);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expAddr(input int idx, input bit wide);
    logic [7:0] w;
    case (idx)
      0: w = 8'h00;
      1: w = 8'h3E;
      2, 3, 4: w = 8'(MAC_BASE + idx - 2);
      5: w = 8'h14;
      default: w = 8'h15;
    endcase
    return wide ? w : (w & 8'h3F);
  endfunction

  task automatic fillMem(input bit idOk);
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    mem[0] = idOk ? ID_VAL : (ID_VAL ^ 16'(1 + ($urandom % 16'hFFFE)));
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) reloadReq = 1'b1;
    else if (which == 1) qryReq = 1'b1;
    else hostWrReq = 1'b1;
    @(negedge clk);
    reloadReq = 1'b0; qryReq = 1'b0; hostWrReq = 1'b0;
  endtask

  task automatic waitIdle();
    int g = 0;
    while (busy && g < 2000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic checkLoad(input bit wide, input bit idOk, input bit staleExp, input string tag);
    int nat = idOk ? 7 : 5;
    int n   = (errIdx >= 0 && errIdx < nat) ? errIdx + 1 : nat;
    int e   = (errIdx >= 0 && errIdx < nat) ? errIdx : 99;
    bit failExp = (e != 99) || !idOk;
    bit cacheExp = !staleExp;
    logic [47:0] macExp;
    logic [7:0] verExp;
    logic rfExp;
    logic [3:0] trimExp;
    chk(readsSeen == n, {tag, " R2 read count"}, readsSeen, n);
    for (int i = 0; i < n && i < 16; i++)
      chk(logAddr[i] == expAddr(i, wide), {tag, " R2/R7 read address"}, logAddr[i], expAddr(i, wide));
    verExp = (e > 1) ? mem[expAddr(1, wide)][15:8] : 8'h00;
    for (int k = 0; k < 3; k++)
      macExp[16*k +: 16] = (e > 2 + k) ? mem[expAddr(2 + k, wide)] : 16'h0;
    rfExp   = (idOk && e > 5) ? mem[expAddr(5, wide)][7] : 1'b0;
    trimExp = (idOk && e > 6) ? mem[expAddr(6, wide)][15:12] : 4'h0;
    chk(verByte == verExp, {tag, " R3 version"}, verByte, verExp);
    chk(macAddr == macExp, {tag, " R4 mac"}, macAddr, macExp);
    chk(rfType == rfExp, {tag, " R6/R5 rf type"}, rfType, rfExp);
    chk(xtalTrim == trimExp, {tag, " R6/R5 trim"}, xtalTrim, trimExp);
    chk(loadFail == failExp, {tag, " R5/R10 fail flag"}, loadFail, failExp);
    chk(cached == cacheExp, {tag, " R8/R11 cached"}, cached, cacheExp);
    chk(fieldValid == (cacheExp && !failExp), {tag, " R8 valid"}, fieldValid, cacheExp && !failExp);
    chk(rdWide == wide, {tag, " R7 width"}, rdWide, wide);
  endtask

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd2718);
    // reset state
    fillMem(1);
    cfgWideAddr = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !rdReq && !cached && !fieldValid, "R8 reset state", {busy, rdReq, cached, fieldValid}, 0);
    // R1 boot load; width changed mid-load must not matter (R7)
    readsSeen = 0; errIdx = -1;
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 boot starts", busy, 1);
    cfgWideAddr = 1'b0;
    @(negedge clk);
    chk(cached == 1'b0, "R8 cached low while loading", cached, 0);
    waitIdle();
    checkLoad(1, 1, 0, "boot");

    // R5 mismatch with narrow addresses, R12 reload while cached
    fillMem(0); readsSeen = 0; cfgWideAddr = 1'b0;
    pulse(0); waitIdle();
    checkLoad(0, 0, 0, "mismatch R12");

    // R9 query while cached does nothing
    fillMem(1); readsSeen = 0;
    pulse(0); waitIdle();
    checkLoad(0, 1, 0, "narrow ok");
    readsSeen = 0;
    pulse(1); repeat (8) @(negedge clk);
    chk(readsSeen == 0 && !busy, "R9 query while cached no read", readsSeen, 0);

    // R9 host write clears cache, query reloads
    @(negedge clk); hostWrReq = 1'b1;
    @(negedge clk); hostWrReq = 1'b0;
    chk(cached == 1'b0 && fieldValid == 1'b0, "R9 write clears cached", cached, 0);
    cfgWideAddr = 1'b1; readsSeen = 0;
    pulse(1); waitIdle();
    checkLoad(1, 1, 0, "R9 query reload");

    // R11 write during load
    readsSeen = 0;
    pulse(0); repeat (3) @(negedge clk);
    hostWrReq = 1'b1; @(negedge clk); hostWrReq = 1'b0;
    waitIdle();
    checkLoad(1, 1, 1, "R11 stale");
    readsSeen = 0;
    pulse(1); waitIdle();
    checkLoad(1, 1, 0, "R11 requery");

    // R10 errors at chosen positions
    readsSeen = 0; errIdx = 3; errBoth = 0;
    pulse(0); waitIdle();
    checkLoad(1, 1, 0, "R10 err3");
    readsSeen = 0; errIdx = 6; errBoth = 1;
    pulse(0); waitIdle();
    checkLoad(1, 1, 0, "R10 err6 both");
    readsSeen = 0; errIdx = 0; errBoth = 1;
    pulse(0); waitIdle();
    checkLoad(1, 1, 0, "R10 err0 both");

    // random mix
    for (int it = 0; it < 24; it++) begin
      bit w = 1'($urandom);
      bit ok = 1'($urandom);
      fillMem(ok);
      cfgWideAddr = w;
      errIdx = ($urandom % 2) ? -1 : int'($urandom % 7);
      errBoth = 1'($urandom);
      readsSeen = 0;
      pulse(0); waitIdle();
      checkLoad(w, ok, 0, "random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule